// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column-address sequence that an SDRAM device walks through during a read or write burst. A mode word, loaded whenever software or a controller programs the device, selects the burst length, the burst ordering (sequential or interleaved), and whether writes are cut down to a single beat while reads keep the programmed length.

A column command (read or write) gives the starting column. From the next clock on, the block presents one column per cycle on `col_out` with `burst_active` high. The burst ends when its length is used up, when a burst stop arrives, or when a new column command restarts the sequence. A full-page burst runs around the whole page until it is stopped or interrupted. Bursts and column commands can arrive back to back.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `burst_active` is 0 and `col_out` is 0. The mode register resets to all zeros, which means length 1, sequential order and single-write mode off.
- R2: The burst-length field is mode bits [2:0]: 000=1, 001=2, 010=4, 011=8 and 111=full page. With mode bit 3 at 0 (sequential), beat k of a burst of length L shows the start column's L-aligned block base plus ((start mod L)+k) mod L.
- R3: With mode bit 3 at 1 (interleaved), beat k shows the L-aligned block base plus ((start mod L) XOR k). The bits above the block do not change during a non-full-page burst.
- R4: A sequential full-page burst shows (start+k) mod 2048 on beat k. It wraps past column 2047 to 0 and never ends by itself.
- R5: The codes 100, 101 and 110 are treated as length 1. Code 111 combined with interleaved order is also treated as length 1.
- R6: A column command sampled at clock edge t sets `burst_active` high from edge t+1 for exactly L cycles, with beat 0 equal to the start column. No non-full-page burst lasts longer than 8 beats.
- R7: A burst stop sampled at an edge with no column command drops `burst_active` after that edge. When a stop and a column command arrive together, the command wins.
- R8: A column command during an active burst restarts the sequence at beat 0 from the new column on the very next cycle, using the current mode.
- R9: With mode bit 9 at 1, every write burst lasts one beat, and read bursts keep the programmed length and order.
- R10: The mode word is captured only when `mode_load` is high. A burst uses the mode that was in force when its command was sampled, so a load during a burst does not change that burst.
- R11: `burst_write` equals the write flag of the command that started the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` at this edge |
| mode_word | input | MODE_W (13) | Mode word: [2:0] length code, [3] order, [9] single-write mode |
| cmd_valid | input | 1 | Column command present |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W (11) | Starting column of the command |
| burst_stop | input | 1 | Terminate the current burst |
| col_out | output | COL_W (11) | Column of the current beat |
| burst_active | output | 1 | A beat is being presented |
| burst_write | output | 1 | Direction of the current burst |

## Verification
Sequential bursts of lengths 2, 4 and 8 are started from columns that are not aligned to the block. This separates a wrap inside the block from a plain increment. Interleaved bursts are started from the same kind of columns, so XOR ordering cannot be mistaken for sequential ordering. A full-page burst started near column 2047 shows the page wrap. Reserved length codes and full page combined with interleave must each give exactly one beat. Interrupting commands, stops that arrive alone or together with a command, single-write mode with both read and write, and a mode load in the middle of a burst each show which piece of state a burst keeps and which it drops.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Field positions inside the mode word
  localparam int unsigned LEN_LSB  = 0;
  localparam int unsigned TYPE_BIT = 3;
  localparam int unsigned BRSW_BIT = 9;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic       brsw;
  } mode_t;

  // log2 of the burst length for the short codes; 0 (length 1) otherwise
  function automatic logic [1:0] len_log2(input logic [2:0] code);
    case (code)
      BL_2:    return 2'd1;
      BL_4:    return 2'd2;
      BL_8:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // Column for a beat: block base kept, low bits stepped or XORed
  function automatic logic [15:0] beat_col(input logic [15:0] start,
                                           input logic [15:0] beat,
                                           input logic [15:0] mask,
                                           input logic        ilv);
    logic [15:0] low;
    low = ilv ? (start ^ beat) : (start + beat);
    return (start & ~mask) | (low & mask);
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter int unsigned MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode_q
);

  mode_t decoded;
  logic  mode_unused;

  assign decoded.len_code = word[LEN_LSB +: 3];
  assign decoded.ilv      = word[TYPE_BIT];
  assign decoded.brsw     = word[BRSW_BIT];
  assign mode_unused      = ^word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= decoded;
  end

endmodule

// File: rtl/colgen_cfg.sv
module colgen_cfg
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 11
) (
  input  colgen_pkg::mode_t mode,
  input  logic              is_write,
  output logic [COL_W-1:0]  eff_mask,
  output logic              eff_ilv,
  output logic              eff_full
);

  logic single_beat;
  logic page_ok;

  assign single_beat = is_write && mode.brsw;
  assign page_ok     = (mode.len_code == BL_PAGE) && !mode.ilv;

  always_comb begin
    eff_ilv  = mode.ilv;
    eff_full = 1'b0;
    if (single_beat) begin
      eff_mask = '0;
    end else if (page_ok) begin
      eff_mask = '1;
      eff_full = 1'b1;
    end else begin
      eff_mask = (COL_W'(1) << len_log2(mode.len_code)) - COL_W'(1);
    end
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
  parameter int unsigned COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             burst_stop,
  input  logic [COL_W-1:0] new_mask,
  input  logic             new_ilv,
  input  logic             new_full,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             full_q,
  output logic             active_q,
  output logic             write_q,
  output logic             burst_end
);

  logic last_beat;

  assign last_beat = !full_q && (beat_q == mask_q);
  assign burst_end = active_q && !cmd_valid && (burst_stop || last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      active_q <= 1'b0;
      write_q  <= 1'b0;
    end else if (cmd_valid) begin
      start_q  <= cmd_col;
      beat_q   <= '0;
      mask_q   <= new_mask;
      ilv_q    <= new_ilv;
      full_q   <= new_full;
      active_q <= 1'b1;
      write_q  <= cmd_write;
    end else if (burst_end) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      beat_q   <= beat_q + COL_W'(1);
    end
  end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 11
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [15:0] wide;

  assign wide = beat_col(16'(start), 16'(beat), 16'(mask), ilv);
  assign col  = wide[COL_W-1:0];

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W  = 11,
  parameter int unsigned MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              burst_stop,
  output logic [COL_W-1:0]  col_out,
  output logic              burst_active,
  output logic              burst_write
);

  mode_t            mode_q;
  logic [COL_W-1:0] new_mask;
  logic             new_ilv;
  logic             new_full;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             cur_full;
  logic             burst_end;
  logic             mode_brsw;

  assign mode_brsw = mode_q.brsw;

  colgen_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word), .mode_q(mode_q)
  );

  colgen_cfg #(.COL_W(COL_W)) u_cfg (
    .mode(mode_q), .is_write(cmd_write),
    .eff_mask(new_mask), .eff_ilv(new_ilv), .eff_full(new_full)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .burst_stop(burst_stop), .new_mask(new_mask),
    .new_ilv(new_ilv), .new_full(new_full), .start_q(start_q), .beat_q(beat_q),
    .mask_q(mask_q), .ilv_q(ilv_q), .full_q(cur_full), .active_q(burst_active),
    .write_q(burst_write), .burst_end(burst_end)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .start(start_q), .beat(beat_q), .mask(mask_q), .ilv(ilv_q), .col(col_out)
  );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int unsigned COL_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [COL_W-1:0] cmd_col,
  input logic             burst_stop,
  input logic [COL_W-1:0] col_out,
  input logic             burst_active,
  input logic             burst_write,
  input logic             cur_full,
  input logic             mode_brsw,
  input logic             burst_end
);

  logic [3:0] beats_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                beats_seen <= '0;
    else if (cmd_valid)                        beats_seen <= 4'd1;
    else if (burst_active && beats_seen != 4'hF) beats_seen <= beats_seen + 4'd1;
  end

  // R8 / R6: a command starts at its own column on the next cycle
  p_start_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> burst_active && col_out == $past(cmd_col));

  // R7: a lone stop ends the burst
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && burst_stop && !cmd_valid |=> !burst_active);

  // R7: the end event and a command never coincide
  p_end_vs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !burst_active);

  // R4: full-page bursts step by one with wrap
  p_page_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && cur_full && !cmd_valid && !burst_stop |=>
      burst_active && col_out == $past(col_out) + COL_W'(1));

  // R3: bits above the 8-column block hold inside a short burst
  p_block_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && !cur_full && !cmd_valid |=>
      !burst_active || ((col_out >> 3) == ($past(col_out) >> 3)));

  // R6: a short burst never exceeds 8 beats
  p_len_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && !cur_full |-> beats_seen <= 4'd8);

  // R9: single-write mode ends a write after one beat
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && mode_brsw |=> ##1 (!burst_active || $past(cmd_valid)));

  // R11: direction follows the starting command
  p_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> burst_write == $past(cmd_write));

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_colgen_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_col(cmd_col), .burst_stop(burst_stop), .col_out(col_out),
  .burst_active(burst_active), .burst_write(burst_write), .cur_full(cur_full),
  .mode_brsw(mode_brsw), .burst_end(burst_end)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;

  localparam int COL_W  = 11;
  localparam int MODE_W = 13;
  localparam int PAGE   = 2048;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_load = 1'b0;
  logic [MODE_W-1:0] mode_word = '0;
  logic              cmd_valid = 1'b0;
  logic              cmd_write = 1'b0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic              burst_stop = 1'b0;
  logic [COL_W-1:0]  col_out;
  logic              burst_active;
  logic              burst_write;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .burst_stop(burst_stop), .col_out(col_out), .burst_active(burst_active),
    .burst_write(burst_write)
  );

  typedef struct { int col; bit wr; int req; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  bit mon_en = 1'b0;

  // bench copy of the mode in force and of the burst in progress
  int m_code = 0; bit m_ilv = 0; bit m_brsw = 0;
  int b_start = 0; int b_len = 1; bit b_ilv = 0; bit b_wr = 0;

  function automatic int eff_len(int code, bit ilv, bit wr, bit brsw);
    if (wr && brsw) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return ilv ? 1 : PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int model_col(int s, int k, int len, bit ilv);
    int base, off;
    base = s - (s % len);
    off  = s % len;
    if (ilv && len < PAGE) off = off ^ k;
    else                   off = (off + k) % len;
    return base + off;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops one expected beat per active cycle
  always @(negedge clk) begin
    if (mon_en && burst_active) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 beat beyond burst", int'(col_out), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(col_out) == e.col, $sformatf("R%0d column", e.req), int'(col_out), e.col);
        check(burst_write == e.wr, "R11 direction", int'(burst_write), int'(e.wr));
      end
    end
  end

  task automatic push_beats(int k0, int k1, int req);
    for (int k = k0; k <= k1; k++) begin
      exp_t e;
      e.col = model_col(b_start, k, b_len, b_ilv);
      e.wr  = b_wr;
      e.req = req;
      exp_q.push_back(e);
    end
  endtask

  // called at a negedge; returns at the negedge showing beat nb-1
  task automatic go(int col, bit wr, int nb, int req);
    b_start = col; b_wr = wr; b_ilv = m_ilv;
    b_len = eff_len(m_code, m_ilv, wr, m_brsw);
    push_beats(0, nb - 1, req);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = COL_W'(col);
    @(negedge clk);
    cmd_valid = 1'b0; burst_stop = 1'b0;
    repeat (nb - 1) @(negedge clk);
  endtask

  task automatic run_on(int k0, int k1, int req);
    push_beats(k0, k1, req);
    repeat (k1 - k0 + 1) @(negedge clk);
  endtask

  task automatic idle(int n, string req);
    repeat (n) begin
      @(negedge clk);
      check(!burst_active, req, int'(burst_active), 0);
    end
    check(exp_q.size() == 0, {req, " missing beats"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic set_mode(int code, bit ilv, bit brsw);
    mode_word = '0;
    mode_word[2:0] = 3'(code);
    mode_word[3] = ilv;
    mode_word[9] = brsw;
    mode_word[6:4] = 3'b010;
    mode_load = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
    m_code = code; m_ilv = ilv; m_brsw = brsw;
  endtask

  task automatic stop_now(string req);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check(!burst_active, req, int'(burst_active), 0);
    check(exp_q.size() == 0, {req, " missing beats"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!burst_active, "R1 active", int'(burst_active), 0);
    check(col_out == '0, "R1 column", int'(col_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    // R1: reset mode gives single-beat bursts
    go(13, 0, 1, 1);
    idle(2, "R1 default length");

    // R2: sequential wrap inside block
    set_mode(2, 0, 0);
    go(6, 0, 4, 2);  idle(1, "R2 len4 end");
    set_mode(3, 0, 0);
    go(13, 1, 8, 2); idle(1, "R2 len8 end");
    set_mode(1, 0, 0);
    go(3, 0, 2, 2);  idle(1, "R2 len2 end");

    // R3: interleaved order
    set_mode(3, 1, 0);
    go(13, 0, 8, 3); idle(1, "R3 len8 end");
    set_mode(2, 1, 0);
    go(6, 1, 4, 3);  idle(1, "R3 len4 end");

    // R4: full page wraps and continues until stopped
    set_mode(7, 0, 0);
    go(2045, 0, 12, 4);
    stop_now("R4 R7 stop ends page burst");

    // R5: full page with interleave, and a reserved code
    set_mode(7, 1, 0);
    go(100, 0, 1, 5); idle(2, "R5 page+interleave is one beat");
    set_mode(5, 0, 0);
    go(77, 1, 1, 5);  idle(2, "R5 reserved code is one beat");

    // R8: interrupting command restarts from new column
    set_mode(3, 0, 0);
    go(0, 0, 3, 8);
    go(21, 1, 8, 8);
    idle(1, "R8 restarted burst end");

    // R7: stop and command together, command wins
    go(50, 0, 2, 7);
    burst_stop = 1'b1;
    go(42, 0, 8, 7);
    idle(1, "R7 command over stop");

    // R9: single-write mode
    set_mode(3, 0, 1);
    go(9, 1, 1, 9);  idle(2, "R9 write one beat");
    go(9, 0, 8, 9);  idle(1, "R9 read full length");

    // R10: mode load mid-burst does not disturb the burst
    set_mode(3, 0, 0);
    go(16, 0, 3, 10);
    push_beats(3, 3, 10);
    set_mode(1, 1, 0);
    run_on(4, 7, 10);
    idle(1, "R10 burst kept old length");
    go(5, 0, 2, 10);
    idle(1, "R10 new mode used");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule